// File: doc/BRIEF.md
# Programmable Precision Interval Timer

This block is a host-programmed interval timer. Software fills a 16-bit holding buffer whose top four bits choose a time base and whose low twelve bits give an interval length. A start command copies the buffer into the active reload register and the 12-bit down counter. The counter then loses one count per period of the chosen base, which is 1 us, 10 us, 100 us or 1 ms. All four bases come from a shared prescaler driven by the system clock.

When the count runs out, the timer requests an interrupt if the request is armed. It then takes the buffer contents again as its new rate and interval, so it either keeps running or halts on a zero rate field. Software can change the next interval at any time without stopping the current one. A byte write that is only half finished when the count runs out is reported as an overflow. The host reads the count and writes the buffer in bytes, high byte first, or in 16-bit halfwords. A sense-status access reports and clears the overflow and the pending interrupt.

Host access is one request per cycle. `host_op` encodes the request: 0 = byte read of count, 1 = halfword read of count, 2 = byte write to buffer, 3 = halfword write to buffer, 4 = sense status, 5 = command. Read results appear on `host_rdata`.

Top module: `prec_interval_timer`

## Requirements
- R1: A halfword write (op 3) loads all 16 buffer bits. Bits 15:12 form the rate field and bits 11:0 the interval count.
- R2: Byte writes (op 2) take `host_wdata[7:0]` into the buffer's high byte first and then its low byte, alternating on each byte write. A halfword write returns the write pointer to the high byte.
- R3: Byte reads (op 0) return the current count's high byte first and then its low byte, alternating on each byte read, in `host_rdata[7:0]`. A halfword read (op 1) returns the count in bits 11:0 with bits 15:12 zero, and returns the read pointer to the high byte.
- R4: A command (op 5) with `host_wdata[5]` set loads the reload register and counter from the buffer. It clears the overflow flag and both byte pointers, and starts counting only when the rate field is nonzero. With a zero rate field, reads return the loaded count unchanged.
- R5: The lowest set bit of the rate field picks the base: bit 12 gives 1 us, bit 13 gives 10 us, bit 14 gives 100 us, bit 15 gives 1 ms. One microsecond lasts `CLK_PER_US` clocks. An interval of N ticks ends N base periods after the start command's clock edge.
- R6: A loaded count of zero expires after exactly one tick.
- R7: On expiry the counter reloads from the buffer as it stands at that moment. The timer keeps running with the new rate, or halts if the new rate field is zero; a halted count holds its loaded value.
- R8: Expiry while the write pointer points at the low byte (one byte of a pair written) sets the overflow flag.
- R9: A sense-status read (op 4) returns the overflow flag in bit 3 with all other bits zero. It then clears the overflow flag and the pending interrupt.
- R10: Command bits 7:6 control the interrupt: 01 enables and arms it, 10 disables it, 11 disarms it, 00 leaves it unchanged.
- R11: Expiry sets the pending interrupt only when the interrupt is armed. `irq` is the pending level gated by enable, and it stays set until a sense-status read or reset clears it.
- R12: Reset stops the counter, clears the reload register, counter, overflow flag and both pointers, and leaves the interrupt clear, disabled and disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, one access per cycle |
| host_op | input | 3 | Access code (0 to 5, see above) |
| host_wdata | input | 16 | Write data for buffer writes and commands |
| host_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request level |

## Verification
`host_rdata` becomes valid on the clock edge that takes the request, so the bench drives requests on falling edges and samples on the next falling edge. Expiry timing is measured in whole clocks from the start command's edge. The expected count is the interval times the base length times `CLK_PER_US`, because `irq` follows the pending flag with no further register. Interrupt control, overflow and sense effects show one edge after their request, and the bench reads them at the next falling edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    OP_RD_BYTE = 3'd0,
    OP_RD_HALF = 3'd1,
    OP_WR_BYTE = 3'd2,
    OP_WR_HALF = 3'd3,
    OP_SENSE   = 3'd4,
    OP_CMD     = 3'd5
  } pit_op_e;

  localparam int CMD_START_BIT = 5;
  localparam int SENSE_OVF_BIT = 3;

  localparam logic [1:0] IC_KEEP   = 2'b00;
  localparam logic [1:0] IC_ENARM  = 2'b01;
  localparam logic [1:0] IC_DIS    = 2'b10;
  localparam logic [1:0] IC_DISARM = 2'b11;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int CLK_PER_US = 100,
  parameter int STAGES     = 4,
  parameter int DECADE     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [STAGES-1:0] tick
);
  localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int DW = $clog2(DECADE);

  logic [UW-1:0] us_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) us_cnt_q <= '0;
    else if (tick[0])   us_cnt_q <= '0;
    else                us_cnt_q <= us_cnt_q + 1'b1;
  end

  assign tick[0] = (us_cnt_q == UW'(CLK_PER_US - 1));

  for (genvar k = 1; k < STAGES; k++) begin : g_decade
    logic [DW-1:0] dec_q;
    always_ff @(posedge clk) begin
      if (rst || restart) dec_q <= '0;
      else if (tick[k-1]) dec_q <= (dec_q == DW'(DECADE - 1)) ? '0 : dec_q + 1'b1;
    end
    assign tick[k] = tick[k-1] && (dec_q == DW'(DECADE - 1));
  end

  if (CLK_PER_US > 1) begin : g_chk
    p_us_spacing_r5: assert property (@(posedge clk) disable iff (rst)
      tick[0] |=> !tick[0]);
  end
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
  parameter int CW = 12,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW+CW-1:0] buf_word,
  input  logic [RW-1:0] tick,
  output logic [CW-1:0] cur,
  output logic          expire
);
  logic [RW+CW-1:0] rel_q;
  logic [CW-1:0]    cur_q;
  logic             run_q;
  logic             base_tick;
  logic             last_tick;

  always_comb begin
    base_tick = 1'b0;
    for (int i = RW - 1; i >= 0; i--) begin
      if (rel_q[CW+i]) base_tick = tick[i];
    end
  end

  assign last_tick = (cur_q <= CW'(1));
  assign expire    = run_q && base_tick && last_tick && !start;
  assign cur       = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= '0;
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (start || expire) begin
      rel_q <= buf_word;
      cur_q <= buf_word[CW-1:0];
      run_q <= |buf_word[RW+CW-1:CW];
    end else if (run_q && base_tick) begin
      cur_q <= cur_q - 1'b1;
    end
  end

  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start) |=> $stable(cur_q));
  p_reload_on_expiry_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cur_q == $past(buf_word[CW-1:0])));
  p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (rel_q == $past(buf_word)));
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [2:0]    op,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cur,
  input  logic          ovf,
  output logic [DW-1:0] buf_word,
  output logic          wptr,
  output logic          start,
  output logic          sense,
  output logic          cmd,
  output logic [DW-1:0] rdata
);
  localparam int BW = DW / 2;

  pit_op_e       op_e;
  logic [DW-1:0] cnt_ext;
  logic          rptr_q;
  logic          wptr_q;
  logic [DW-1:0] buf_q;
  logic [DW-1:0] rdata_q;

  assign op_e    = pit_op_e'(op);
  assign cnt_ext = DW'(cur);
  assign cmd     = req && (op_e == OP_CMD);
  assign start   = cmd && wdata[CMD_START_BIT];
  assign sense   = req && (op_e == OP_SENSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= 1'b0;
      wptr_q  <= 1'b0;
      buf_q   <= '0;
      rdata_q <= '0;
    end else if (req) begin
      unique case (op_e)
        OP_RD_BYTE: begin
          rdata_q <= rptr_q ? DW'(cnt_ext[BW-1:0]) : DW'(cnt_ext[DW-1:BW]);
          rptr_q  <= ~rptr_q;
        end
        OP_RD_HALF: begin
          rdata_q <= cnt_ext;
          rptr_q  <= 1'b0;
        end
        OP_WR_BYTE: begin
          if (wptr_q) buf_q[BW-1:0]  <= wdata[BW-1:0];
          else        buf_q[DW-1:BW] <= wdata[BW-1:0];
          wptr_q <= ~wptr_q;
        end
        OP_WR_HALF: begin
          buf_q  <= wdata;
          wptr_q <= 1'b0;
        end
        OP_SENSE: begin
          rdata_q <= '0;
          rdata_q[SENSE_OVF_BIT] <= ovf;
        end
        OP_CMD: begin
          if (wdata[CMD_START_BIT]) begin
            rptr_q <= 1'b0;
            wptr_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign buf_word = buf_q;
  assign wptr     = wptr_q;
  assign rdata    = rdata_q;

  p_half_read_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (req && op_e == OP_RD_HALF) |=> !rptr_q);
  p_half_write_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    (req && op_e == OP_WR_HALF) |=> (!wptr_q && buf_q == $past(wdata)));
  p_start_ptrs_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (!rptr_q && !wptr_q));
endmodule

// File: rtl/prec_interval_timer.sv
module prec_interval_timer
  import pit_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int DW         = 16,
  parameter int CW         = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic [2:0]    host_op,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq
);
  localparam int RW = DW - CW;

  logic [DW-1:0] buf_word;
  logic          wptr;
  logic          start;
  logic          sense;
  logic          cmd;
  logic [RW-1:0] tick;
  logic [CW-1:0] cur;
  logic          expire;
  logic          ovf_q;
  logic          en_q;
  logic          arm_q;
  logic          pend_q;

  pit_host_if #(.DW(DW), .CW(CW)) u_host (
    .clk(clk), .rst(rst), .req(host_req), .op(host_op), .wdata(host_wdata),
    .cur(cur), .ovf(ovf_q), .buf_word(buf_word), .wptr(wptr),
    .start(start), .sense(sense), .cmd(cmd), .rdata(host_rdata)
  );

  pit_prescaler #(.CLK_PER_US(CLK_PER_US), .STAGES(RW), .DECADE(10)) u_pre (
    .clk(clk), .rst(rst), .restart(start), .tick(tick)
  );

  pit_count_core #(.CW(CW), .RW(RW)) u_core (
    .clk(clk), .rst(rst), .start(start), .buf_word(buf_word),
    .tick(tick), .cur(cur), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      en_q   <= 1'b0;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (start)               ovf_q <= 1'b0;
      else if (expire && wptr) ovf_q <= 1'b1;
      else if (sense)          ovf_q <= 1'b0;

      if (expire && arm_q) pend_q <= 1'b1;
      else if (sense)      pend_q <= 1'b0;

      if (cmd) begin
        unique case (host_wdata[7:6])
          IC_ENARM:  begin en_q <= 1'b1; arm_q <= 1'b1; end
          IC_DIS:    en_q  <= 1'b0;
          IC_DISARM: arm_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign irq = pend_q && en_q;

  p_sense_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (sense && !expire) |=> (!ovf_q && !pend_q));
  p_armed_only_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(arm_q));
  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(wptr));
  p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !sense) |=> pend_q);
endmodule

// File: tb/tb_prec_interval_timer.sv
module tb_prec_interval_timer;
  localparam int CPU = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic [2:0]  host_op = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] rd;

  prec_interval_timer #(.CLK_PER_US(CPU)) dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_op(host_op),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // buffer word, expected clocks from start to irq (CPU = 2)
  localparam logic [31:0] VEC [8] = '{
    {16'h1003, 16'd6},    {16'h2002, 16'd40},  {16'h4001, 16'd200},
    {16'h8002, 16'd4000}, {16'h1000, 16'd2},   {16'h3005, 16'd10},
    {16'hC001, 16'd200},  {16'hA003, 16'd60}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] code, input logic [15:0] data);
    @(negedge clk);
    host_req = 1'b1; host_op = code; host_wdata = data;
    @(negedge clk);
    host_req = 1'b0;
    rd = host_rdata;
  endtask

  task automatic wait_irq(output int n, input int lim);
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 irq", irq, 0);
    op(3'd1, 0); chk("R12 count", rd, 16'h0000);
    op(3'd4, 0); chk("R12 sense", rd, 16'h0000);

    // R5 R6 R1 timing table
    for (int i = 0; i < 8; i++) begin
      op(3'd3, VEC[i][31:16]);
      op(3'd5, 16'h0060);
      wait_irq(n, 10000);
      chk($sformatf("R5/R6 vec%0d cycles", i), n, VEC[i][15:0]);
      op(3'd3, 16'h0000);
      op(3'd5, 16'h0020);
      op(3'd4, 0);
      chk("R9 irq cleared", irq, 0);
    end

    // R3 byte and halfword reads, stopped counter (R4)
    op(3'd3, 16'h0ABC); op(3'd5, 16'h0020);
    op(3'd0, 0); chk("R3 rd hi", rd, 16'h000A);
    op(3'd0, 0); chk("R3 rd lo", rd, 16'h00BC);
    op(3'd0, 0); chk("R3 rd hi again", rd, 16'h000A);
    op(3'd1, 0); chk("R3 rd half", rd, 16'h0ABC);
    op(3'd0, 0); chk("R3 ptr reset", rd, 16'h000A);
    repeat (20) @(negedge clk);
    op(3'd1, 0); chk("R4 stopped hold", rd, 16'h0ABC);

    // R2 byte writes
    op(3'd2, 16'h000F); op(3'd2, 16'h00ED); op(3'd5, 16'h0020);
    op(3'd1, 0); chk("R2 byte pair", rd, 16'h0FED);
    op(3'd2, 16'h0001); op(3'd3, 16'h0123); op(3'd2, 16'h0004); op(3'd5, 16'h0020);
    op(3'd1, 0); chk("R2 half resets ptr", rd, 16'h0423);
    op(3'd2, 16'h0005); op(3'd5, 16'h0020); op(3'd2, 16'h0006); op(3'd5, 16'h0020);
    op(3'd1, 0); chk("R4 start resets wptr", rd, 16'h0623);

    // R8 overflow on half-written pair, R9 sense
    op(3'd3, 16'h1014); op(3'd5, 16'h0060);
    op(3'd2, 16'h0010);
    wait_irq(n, 1000);
    chk("R11 irq on expiry", irq, 1);
    op(3'd4, 0); chk("R8 ovf sensed", rd, 16'h0008);
    chk("R9 irq cleared by sense", irq, 0);
    op(3'd4, 0); chk("R9 ovf cleared", rd, 16'h0000);

    // R7 periodic continuation
    op(3'd3, 16'h1003); op(3'd5, 16'h0060);
    wait_irq(n, 1000); op(3'd4, 0);
    wait_irq(n, 1000); chk("R7 periodic second irq", irq, 1);
    op(3'd4, 0);
    // R7 stop on zero rate reload
    op(3'd3, 16'h1004); op(3'd5, 16'h0060);
    op(3'd3, 16'h0007);
    wait_irq(n, 1000);
    chk("R7 expiry before stop", irq, 1);
    op(3'd1, 0); chk("R7 halted count", rd, 16'h0007);
    repeat (30) @(negedge clk);
    op(3'd1, 0); chk("R7 still halted", rd, 16'h0007);
    op(3'd4, 0);

    // R10 R11 disarm
    op(3'd3, 16'h1002); op(3'd5, 16'h0060); op(3'd5, 16'h00C0);
    repeat (20) @(negedge clk);
    chk("R10 disarmed no irq", irq, 0);
    op(3'd5, 16'h0040); repeat (20) @(negedge clk);
    chk("R10 rearmed irq", irq, 1);
    op(3'd5, 16'h0080); chk("R10 disabled masks", irq, 0);
    op(3'd5, 16'h0000); chk("R10 keep code", irq, 0);
    op(3'd5, 16'h0040); chk("R11 pending held", irq, 1);
    op(3'd3, 16'h0000); op(3'd5, 16'h0020); op(3'd4, 0);

    // R12 reset mid-run
    op(3'd3, 16'h1005); op(3'd5, 16'h0060);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    op(3'd1, 0); chk("R12 count cleared", rd, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R12 no irq after reset", irq, 0);
    op(3'd5, 16'h0020); op(3'd1, 0);
    chk("R12 reload cleared", rd, 16'h0000);

    finish_run();
  end
endmodule